// File: doc/BRIEF.md
# Speculative Branch History Tracker

This block records every control-flow instruction that the front end predicts. Each record is kept in program order and carries the instruction's sequence number. Later, the pipeline either retires the records or unwinds them. On a prediction, the block receives the instruction's class, the direction predictor's answer, the target-buffer hit result and the indirect predictor's hit result. From these it forms the final taken flag and the next fetch address. It also runs a small return address stack and saves a checkpoint of the stack top in every record.

Commit requests retire records from the oldest end, one per cycle, up to a given sequence number. The direction predictor uses the retire outputs to train. Squash requests unwind records from the youngest end, and each removed record repairs the return stack in turn. A mispredict request also corrects the record of the branch that went wrong. That correction can repair the stack once more and can write the corrected target into the target buffer.

Top module: `bhist_tracker`

## Requirements
- R1: After reset the history is empty, `pred_ready` is 1, `busy` is 0, the return stack top index is 0 and its top value is 0.
- R2: An unconditional instruction is treated as taken and a conditional one follows `pred_dir_taken`. Whenever the final prediction is not taken, `pred_next_pc` is the PC plus 4.
- R3: A taken non-return takes its target from `btb_target` when `pred_indirect` is 0 and from `ind_target` when it is 1. When the selected hit input is 0, the prediction becomes not taken. In that case a conditional call makes no push, while an unconditional call still pushes.
- R4: A taken call pushes the PC plus 4 onto the return stack. A taken return predicts the stack top value as its target and then pops the stack.
- R5: A commit retires records from the oldest end, one per cycle, while the record's sequence number is at most the commit number. Each retire shows the record's PC, its predicted-taken flag and its corrected flag, and never touches the return stack.
- R6: A squash removes records from the youngest end, one per cycle, while their sequence number exceeds the squash number. A removed record that consumed the stack restores the saved top index and value. A removed call that pushed pops the stack.
- R7: On a mispredict that was actually taken, if the youngest remaining record is a return that did not consume the stack, the stack pops. If that record is not indirect, `btb_wr_valid` pulses with the record's PC and `sq_target`.
- R8: On a mispredict that was actually not taken, a record that consumed the stack restores it. Otherwise, a call that pushed pops the stack. No target-buffer write is made.
- R9: The history holds 16 records. When it is full, `pred_ready` is 0 and a prediction presented then is not stored.
- R10: While idle, a squash request wins over a commit request, which wins over a prediction. While a request is being walked, `busy` is 1 and `pred_ready` is 0.
- R11: A mispredict leaves all records and the stack unchanged if the history is empty or if the youngest remaining sequence number differs from the mispredict number. In the second case `fix_mismatch` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pred_valid | input | 1 | Prediction request |
| pred_seq | input | 16 | Sequence number of the predicted instruction |
| pred_pc | input | 32 | PC of the predicted instruction |
| pred_uncond | input | 1 | Instruction is unconditional |
| pred_call | input | 1 | Instruction is a call |
| pred_ret | input | 1 | Instruction is a return |
| pred_indirect | input | 1 | Instruction has a register target |
| pred_dir_taken | input | 1 | Direction predictor answer |
| btb_hit | input | 1 | Target buffer hit |
| btb_target | input | 32 | Target buffer target |
| ind_hit | input | 1 | Indirect predictor hit |
| ind_target | input | 32 | Indirect predictor target |
| pred_ready | output | 1 | Prediction can be accepted this cycle |
| pred_taken | output | 1 | Final taken prediction |
| pred_next_pc | output | 32 | Predicted next fetch address |
| commit_valid | input | 1 | Commit request |
| commit_seq | input | 16 | Retire records up to this number |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | 16 | Keep records up to this number |
| sq_mispred | input | 1 | Squash is a mispredict of record sq_seq |
| sq_actual_taken | input | 1 | Resolved direction of the mispredicted branch |
| sq_target | input | 32 | Resolved target of the mispredicted branch |
| busy | output | 1 | A commit or squash walk is running |
| retire_valid | output | 1 | A record retires this cycle |
| retire_pc | output | 32 | PC of the retiring record |
| retire_taken | output | 1 | Predicted-taken flag of the retiring record |
| retire_squashed | output | 1 | Retiring record was corrected by a mispredict |
| btb_wr_valid | output | 1 | Target buffer write |
| btb_wr_pc | output | 32 | PC to write |
| btb_wr_target | output | 32 | Target to write |
| fix_mismatch | output | 1 | Mispredict number not found at the youngest end |
| ras_push | output | 1 | Return stack push this cycle |
| ras_pop | output | 1 | Return stack pop this cycle |
| ras_restore | output | 1 | Return stack checkpoint restore this cycle |
| ras_top_idx | output | 3 | Return stack top index |
| ras_top_val | output | 32 | Return stack top value |

## Verification
Predictions are driven through every instruction class: a direct jump, a conditional not taken, a direct call, a return, a conditional call that misses the target buffer, an unconditional call that misses, an indirect jump that hits and an indirect branch that misses while the target buffer hits. Together these separate the two target sources and show whether the call push follows the hit. The squash walks are arranged so that each per-record repair can be seen at the stack top before a later restore overwrites it. Mispredicts are applied in both directions to a return and to a call. A mispredict is also aimed at a missing number and at an empty history. A fill to capacity and a cycle with all three requests at once show the ready gating and the order of request service.

// File: rtl/bhist_pkg.sv
package bhist_pkg;

  localparam int BH_SEQ_W     = 16;
  localparam int BH_PC_W      = 32;
  localparam int BH_RAS_DEPTH = 8;
  localparam int BH_RAS_IW    = $clog2(BH_RAS_DEPTH);
  localparam int BH_STEP      = 4;

  typedef logic [BH_SEQ_W-1:0]  seq_t;
  typedef logic [BH_PC_W-1:0]   pc_t;
  typedef logic [BH_RAS_IW-1:0] ras_idx_t;

  typedef struct packed {
    seq_t     seq;
    pc_t      pc;
    logic     pred_taken;
    logic     was_call;
    logic     was_ret;
    logic     was_ind;
    logic     used_ras;
    logic     pushed_ras;
    ras_idx_t ras_idx;
    pc_t      ras_val;
    logic     squashed;
  } hrec_t;

  typedef enum logic [1:0] {ST_IDLE, ST_COMMIT, ST_SQUASH} walk_e;
  typedef enum logic [1:0] {RAS_NOP, RAS_PUSH, RAS_POP, RAS_RESTORE} ras_op_e;

  function automatic pc_t pc_step(pc_t pc);
    return pc + pc_t'(BH_STEP);
  endfunction

  // repair applied when a record is thrown away by a squash walk
  function automatic ras_op_e undo_op(hrec_t r);
    if (r.used_ras)                   return RAS_RESTORE;
    else if (r.was_call && r.pushed_ras) return RAS_POP;
    else                              return RAS_NOP;
  endfunction

  // repair applied to the mispredicted record itself
  function automatic ras_op_e fix_op(hrec_t r, logic tkn);
    if (tkn) return (r.was_ret && !r.used_ras) ? RAS_POP : RAS_NOP;
    else     return undo_op(r);
  endfunction

  function automatic hrec_t fix_rec(hrec_t r, logic tkn);
    hrec_t o;
    o = r;
    o.squashed = 1'b1;
    if (tkn) begin
      if (r.was_ret && !r.used_ras) o.used_ras = 1'b1;
    end else begin
      if (r.used_ras)                       o.used_ras   = 1'b0;
      else if (r.was_call && r.pushed_ras)  o.pushed_ras = 1'b0;
    end
    return o;
  endfunction

endpackage

// File: rtl/bhist_ras.sv
module bhist_ras
  import bhist_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  ras_op_e  op,
  input  pc_t      wr_val,
  input  ras_idx_t wr_idx,
  output ras_idx_t top_idx,
  output pc_t      top_val
);
  pc_t      slot [BH_RAS_DEPTH];
  ras_idx_t top_q;
  ras_idx_t top_up;

  assign top_up  = top_q + ras_idx_t'(1);
  assign top_idx = top_q;
  assign top_val = slot[top_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      top_q <= '0;
      for (int i = 0; i < BH_RAS_DEPTH; i++) slot[i] <= '0;
    end else begin
      case (op)
        RAS_PUSH: begin
          top_q        <= top_up;
          slot[top_up] <= wr_val;
        end
        RAS_POP:  top_q <= top_q - ras_idx_t'(1);
        RAS_RESTORE: begin
          top_q        <= wr_idx;
          slot[wr_idx] <= wr_val;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bhist_ring.sv
module bhist_ring
  import bhist_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_en,
  input  hrec_t         push_rec,
  input  logic          pop_old,
  input  logic          pop_young,
  input  logic          upd_en,
  input  hrec_t         upd_rec,
  output hrec_t         oldest,
  output hrec_t         youngest,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  hrec_t         mem [DEPTH];
  logic [PW-1:0] old_ptr;
  logic [PW-1:0] new_ptr;
  logic [PW-1:0] young_ptr;
  logic [CW-1:0] cnt;

  assign young_ptr = new_ptr - PW'(1);
  assign oldest    = mem[old_ptr];
  assign youngest  = mem[young_ptr];
  assign count     = cnt;
  assign full      = (cnt == CW'(DEPTH));
  assign empty     = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      old_ptr <= '0;
      new_ptr <= '0;
      cnt     <= '0;
    end else begin
      if (push_en)   new_ptr <= new_ptr + PW'(1);
      if (pop_young) new_ptr <= young_ptr;
      if (pop_old)   old_ptr <= old_ptr + PW'(1);
      cnt <= cnt + CW'(push_en) - CW'(pop_old) - CW'(pop_young);
    end
  end

  always_ff @(posedge clk) begin
    if (push_en) mem[new_ptr]   <= push_rec;
    if (upd_en)  mem[young_ptr] <= upd_rec;
  end
endmodule

// File: rtl/bhist_decide.sv
module bhist_decide
  import bhist_pkg::*;
(
  input  seq_t     seq,
  input  pc_t      pc,
  input  logic     is_uncond,
  input  logic     is_call,
  input  logic     is_ret,
  input  logic     is_ind,
  input  logic     dir_taken,
  input  logic     btb_hit,
  input  pc_t      btb_tgt,
  input  logic     ind_hit,
  input  pc_t      ind_tgt,
  input  ras_idx_t top_idx,
  input  pc_t      top_val,
  output hrec_t    rec,
  output logic     taken,
  output pc_t      next_pc,
  output ras_op_e  op,
  output pc_t      push_val
);
  logic guess;
  logic hit;
  pc_t  tgt;

  assign guess    = is_uncond | dir_taken;
  assign hit      = is_ind ? ind_hit : btb_hit;
  assign tgt      = is_ind ? ind_tgt : btb_tgt;
  assign push_val = pc_step(pc);

  always_comb begin
    rec         = '0;
    rec.seq     = seq;
    rec.pc      = pc;
    rec.was_ret = is_ret;
    rec.ras_idx = top_idx;
    rec.ras_val = top_val;
    taken       = 1'b0;
    next_pc     = pc_step(pc);
    op          = RAS_NOP;
    if (guess && is_ret) begin
      taken        = 1'b1;
      next_pc      = top_val;
      rec.used_ras = 1'b1;
      op           = RAS_POP;
    end else if (guess) begin
      rec.was_call = is_call;
      rec.was_ind  = is_ind;
      if (hit) begin
        taken   = 1'b1;
        next_pc = tgt;
      end
      if (is_call && (hit || is_uncond)) begin
        rec.pushed_ras = 1'b1;
        op             = RAS_PUSH;
      end
    end
    rec.pred_taken = taken;
  end
endmodule

// File: rtl/bhist_tracker.sv
module bhist_tracker
  import bhist_pkg::*;
#(
  parameter int HIST_DEPTH = 16,
  localparam int CNT_W = $clog2(HIST_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pred_valid,
  input  logic [BH_SEQ_W-1:0]  pred_seq,
  input  logic [BH_PC_W-1:0]   pred_pc,
  input  logic                 pred_uncond,
  input  logic                 pred_call,
  input  logic                 pred_ret,
  input  logic                 pred_indirect,
  input  logic                 pred_dir_taken,
  input  logic                 btb_hit,
  input  logic [BH_PC_W-1:0]   btb_target,
  input  logic                 ind_hit,
  input  logic [BH_PC_W-1:0]   ind_target,
  output logic                 pred_ready,
  output logic                 pred_taken,
  output logic [BH_PC_W-1:0]   pred_next_pc,
  input  logic                 commit_valid,
  input  logic [BH_SEQ_W-1:0]  commit_seq,
  input  logic                 sq_valid,
  input  logic [BH_SEQ_W-1:0]  sq_seq,
  input  logic                 sq_mispred,
  input  logic                 sq_actual_taken,
  input  logic [BH_PC_W-1:0]   sq_target,
  output logic                 busy,
  output logic                 retire_valid,
  output logic [BH_PC_W-1:0]   retire_pc,
  output logic                 retire_taken,
  output logic                 retire_squashed,
  output logic                 btb_wr_valid,
  output logic [BH_PC_W-1:0]   btb_wr_pc,
  output logic [BH_PC_W-1:0]   btb_wr_target,
  output logic                 fix_mismatch,
  output logic                 ras_push,
  output logic                 ras_pop,
  output logic                 ras_restore,
  output logic [BH_RAS_IW-1:0] ras_top_idx,
  output logic [BH_PC_W-1:0]   ras_top_val
);
  walk_e    state;
  seq_t     lim_q;
  logic     misp_q;
  logic     tkn_q;
  pc_t      tgt_q;

  hrec_t    oldest;
  hrec_t    youngest;
  hrec_t    new_rec;
  hrec_t    upd_rec;
  logic [CNT_W-1:0] hist_cnt;
  logic     hist_full;
  logic     hist_empty;

  ras_op_e  dec_op;
  pc_t      dec_push_val;
  ras_op_e  ras_op;
  pc_t      ras_wr_val;
  ras_idx_t ras_wr_idx;
  ras_idx_t top_idx;
  pc_t      top_val;

  // named internal events
  logic idle;
  logic pred_fire;
  logic cm_pop;
  logic sq_pop;
  logic sq_final;
  logic fix_en;
  logic lint_unused_bits;

  assign idle       = (state == ST_IDLE);
  assign busy       = !idle;
  assign pred_ready = idle && !hist_full && !sq_valid && !commit_valid;
  assign pred_fire  = pred_valid && pred_ready;

  assign cm_pop   = (state == ST_COMMIT) && !hist_empty && (oldest.seq <= lim_q);
  assign sq_pop   = (state == ST_SQUASH) && !hist_empty && (youngest.seq > lim_q);
  assign sq_final = (state == ST_SQUASH) && !sq_pop;
  assign fix_en   = sq_final && misp_q && !hist_empty && (youngest.seq == lim_q);
  assign fix_mismatch = sq_final && misp_q && !hist_empty && (youngest.seq != lim_q);

  assign lint_unused_bits = ^{oldest, youngest.ras_idx};

  bhist_decide u_decide (
    .seq       (pred_seq),
    .pc        (pred_pc),
    .is_uncond (pred_uncond),
    .is_call   (pred_call),
    .is_ret    (pred_ret),
    .is_ind    (pred_indirect),
    .dir_taken (pred_dir_taken),
    .btb_hit   (btb_hit),
    .btb_tgt   (btb_target),
    .ind_hit   (ind_hit),
    .ind_tgt   (ind_target),
    .top_idx   (top_idx),
    .top_val   (top_val),
    .rec       (new_rec),
    .taken     (pred_taken),
    .next_pc   (pred_next_pc),
    .op        (dec_op),
    .push_val  (dec_push_val)
  );

  assign upd_rec = fix_rec(youngest, tkn_q);

  bhist_ring #(.DEPTH(HIST_DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .push_en   (pred_fire),
    .push_rec  (new_rec),
    .pop_old   (cm_pop),
    .pop_young (sq_pop),
    .upd_en    (fix_en),
    .upd_rec   (upd_rec),
    .oldest    (oldest),
    .youngest  (youngest),
    .count     (hist_cnt),
    .full      (hist_full),
    .empty     (hist_empty)
  );

  // one stack command per cycle: predict, walk or fix are mutually exclusive
  always_comb begin
    ras_op     = RAS_NOP;
    ras_wr_val = dec_push_val;
    ras_wr_idx = youngest.ras_idx;
    if (pred_fire) begin
      ras_op = dec_op;
    end else if (sq_pop) begin
      ras_op     = undo_op(youngest);
      ras_wr_val = youngest.ras_val;
    end else if (fix_en) begin
      ras_op     = fix_op(youngest, tkn_q);
      ras_wr_val = youngest.ras_val;
    end
  end

  assign ras_push    = (ras_op == RAS_PUSH);
  assign ras_pop     = (ras_op == RAS_POP);
  assign ras_restore = (ras_op == RAS_RESTORE);

  bhist_ras u_ras (
    .clk     (clk),
    .rst_n   (rst_n),
    .op      (ras_op),
    .wr_val  (ras_wr_val),
    .wr_idx  (ras_wr_idx),
    .top_idx (top_idx),
    .top_val (top_val)
  );

  assign ras_top_idx = top_idx;
  assign ras_top_val = top_val;

  assign retire_valid    = cm_pop;
  assign retire_pc       = oldest.pc;
  assign retire_taken    = oldest.pred_taken;
  assign retire_squashed = oldest.squashed;

  assign btb_wr_valid  = fix_en && tkn_q && !youngest.was_ind;
  assign btb_wr_pc     = youngest.pc;
  assign btb_wr_target = tgt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      lim_q  <= '0;
      misp_q <= 1'b0;
      tkn_q  <= 1'b0;
      tgt_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sq_valid) begin
            state  <= ST_SQUASH;
            lim_q  <= sq_seq;
            misp_q <= sq_mispred;
            tkn_q  <= sq_actual_taken;
            tgt_q  <= sq_target;
          end else if (commit_valid) begin
            state <= ST_COMMIT;
            lim_q <= commit_seq;
          end
        end
        ST_COMMIT: if (!cm_pop)  state <= ST_IDLE;
        ST_SQUASH: if (sq_final) state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bhist_tracker_chk.sv
module bhist_tracker_chk #(
  parameter int DEPTH = 16,
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pred_ready,
  input logic          busy,
  input logic          sq_valid,
  input logic          ras_push,
  input logic          ras_pop,
  input logic          ras_restore,
  input logic          btb_wr_valid,
  input logic          retire_valid,
  input logic          pred_fire,
  input logic          hist_full,
  input logic [CW-1:0] hist_cnt
);
  AST_BUSY_BLOCKS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pred_ready); // R10
  AST_SQ_TAKES_OVER: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_valid && !busy) |=> busy); // R10
  AST_FULL_BLOCKS_PRED: assert property (@(posedge clk) disable iff (!rst_n)
    hist_full |-> !pred_ready); // R9
  AST_FIRE_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    pred_fire |=> hist_cnt == $past(hist_cnt) + CW'(1)); // R9
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hist_cnt <= CW'(DEPTH)); // R9
  AST_RETIRE_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |=> hist_cnt == $past(hist_cnt) - CW'(1)); // R5
  AST_RETIRE_NO_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> !(ras_push || ras_pop || ras_restore)); // R5
  AST_BTB_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
    btb_wr_valid |-> (busy && !retire_valid && !ras_push)); // R7
endmodule

bind bhist_tracker bhist_tracker_chk #(.DEPTH(HIST_DEPTH), .CW(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .pred_ready   (pred_ready),
  .busy         (busy),
  .sq_valid     (sq_valid),
  .ras_push     (ras_push),
  .ras_pop      (ras_pop),
  .ras_restore  (ras_restore),
  .btb_wr_valid (btb_wr_valid),
  .retire_valid (retire_valid),
  .pred_fire    (pred_fire),
  .hist_full    (hist_full),
  .hist_cnt     (hist_cnt)
);

// File: tb/tb_bhist_tracker.sv
`timescale 1ns/1ps
module tb_bhist_tracker;
  localparam int CLK_PERIOD = 10;
  localparam logic [5:0] K_UNC = 6'b100000, K_CALL = 6'b010000, K_RET = 6'b001000,
                         K_IND = 6'b000100, K_DIR  = 6'b000010, K_BTB = 6'b000001;

  logic clk = 0, rst_n = 0;
  logic pred_valid = 0, pred_uncond = 0, pred_call = 0, pred_ret = 0, pred_indirect = 0;
  logic pred_dir_taken = 0, btb_hit = 0, ind_hit = 0;
  logic [15:0] pred_seq = 0, commit_seq = 0, sq_seq = 0;
  logic [31:0] pred_pc = 0, btb_target = 0, ind_target = 0, sq_target = 0;
  logic commit_valid = 0, sq_valid = 0, sq_mispred = 0, sq_actual_taken = 0;
  logic pred_ready, pred_taken, busy, retire_valid, retire_taken, retire_squashed;
  logic btb_wr_valid, fix_mismatch, ras_push, ras_pop, ras_restore;
  logic [31:0] pred_next_pc, retire_pc, btb_wr_pc, btb_wr_target, ras_top_val;
  logic [2:0] ras_top_idx;

  int n_total = 0, n_bad = 0, n_mism = 0;
  bit done = 0;
  logic [33:0] exp_ret[$];
  logic [63:0] exp_btb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bhist_tracker dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_total++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: compare produced events against the scoreboard queues
  always @(negedge clk) if (rst_n) begin
    if (retire_valid) begin
      if (exp_ret.size() == 0) chk("R5 unexpected retire", {30'd0, retire_pc, retire_taken, retire_squashed}, 64'h0);
      else chk("R5 retire", {retire_pc, retire_taken, retire_squashed}, exp_ret.pop_front());
    end
    if (btb_wr_valid) begin
      if (exp_btb.size() == 0) chk("R7 unexpected btb write", {btb_wr_pc, btb_wr_target}, 64'h0);
      else chk("R7 btb write", {btb_wr_pc, btb_wr_target}, exp_btb.pop_front());
    end
    if (fix_mismatch) n_mism++;
  end

  task automatic predict(input logic [15:0] s, input logic [31:0] pc, input logic [5:0] k,
                         input logic [31:0] bt, input logic ih, input logic [31:0] it,
                         input logic et, input logic [31:0] en, input string req);
    @(posedge clk); #1;
    pred_seq = s; pred_pc = pc;
    {pred_uncond, pred_call, pred_ret, pred_indirect, pred_dir_taken, btb_hit} = k;
    btb_target = bt; ind_hit = ih; ind_target = it; pred_valid = 1;
    #1;
    chk({req, " ready"}, pred_ready, 1);
    chk({req, " taken"}, pred_taken, et);
    chk({req, " next pc"}, pred_next_pc, en);
    @(posedge clk); #1;
    pred_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) begin @(posedge clk); #1; end
  endtask

  task automatic commit(input logic [15:0] s);
    @(posedge clk); #1; commit_valid = 1; commit_seq = s;
    @(posedge clk); #1; commit_valid = 0;
    wait_idle();
  endtask

  task automatic squash(input logic [15:0] s, input logic m, input logic t, input logic [31:0] tg);
    @(posedge clk); #1; sq_valid = 1; sq_seq = s; sq_mispred = m; sq_actual_taken = t; sq_target = tg;
    @(posedge clk); #1; sq_valid = 0;
    wait_idle();
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_total++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_total, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;
    chk("R1 ready", pred_ready, 1);
    chk("R1 busy", busy, 0);
    chk("R1 ras idx", ras_top_idx, 0);
    chk("R1 ras val", ras_top_val, 0);

    predict(1, 32'h100, K_UNC | K_BTB, 32'h200, 0, 0, 1, 32'h200, "R2 uncond jump");
    predict(2, 32'h204, 0, 0, 0, 0, 0, 32'h208, "R2 cond not taken");
    predict(3, 32'h300, K_UNC | K_CALL | K_BTB, 32'h800, 0, 0, 1, 32'h800, "R4 call");
    chk("R4 push idx", ras_top_idx, 1);
    chk("R4 push val", ras_top_val, 32'h304);
    predict(4, 32'h810, K_UNC | K_RET, 0, 0, 0, 1, 32'h304, "R4 return");
    chk("R4 pop idx", ras_top_idx, 0);
    predict(5, 32'h400, K_CALL | K_DIR, 32'h111, 0, 0, 0, 32'h404, "R3 cond call miss");
    chk("R3 no push", ras_top_idx, 0);
    predict(6, 32'h500, K_UNC | K_IND, 32'h222, 1, 32'h900, 1, 32'h900, "R3 indirect hit");

    exp_ret.push_back({32'h100, 1'b1, 1'b0});
    exp_ret.push_back({32'h204, 1'b0, 1'b0});
    exp_ret.push_back({32'h300, 1'b1, 1'b0});
    commit(3);
    chk("R5 retire queue drained", exp_ret.size(), 0);

    predict(7, 32'h600, K_UNC | K_CALL | K_BTB, 32'hA00, 0, 0, 1, 32'hA00, "R4 call 2");
    chk("R4 push val 2", ras_top_val, 32'h604);
    squash(6, 0, 0, 0);
    chk("R6 walk pop idx", ras_top_idx, 0);
    chk("R6 walk pop val", ras_top_val, 0);
    squash(4, 1, 0, 0);
    chk("R8 restore idx", ras_top_idx, 1);
    chk("R8 restore val", ras_top_val, 32'h304);
    exp_btb.push_back({32'h810, 32'h777});
    squash(4, 1, 1, 32'h777);
    chk("R7 return pop idx", ras_top_idx, 0);
    chk("R7 btb queue drained", exp_btb.size(), 0);
    exp_ret.push_back({32'h810, 1'b1, 1'b1});
    commit(4);

    predict(8, 32'h700, K_CALL | K_DIR | K_BTB, 32'hB00, 0, 0, 1, 32'hB00, "R4 cond call");
    chk("R4 cond call push", ras_top_idx, 1);
    squash(8, 1, 0, 0);
    chk("R8 call pop", ras_top_idx, 0);
    exp_ret.push_back({32'h700, 1'b1, 1'b1});
    commit(8);

    predict(9, 32'h720, K_UNC | K_CALL, 32'h0, 0, 0, 0, 32'h724, "R3 uncond call miss");
    chk("R3 uncond call still pushes", ras_top_val, 32'h724);
    squash(8, 0, 0, 0);
    chk("R6 walk pops call", ras_top_idx, 0);

    predict(10, 32'h740, K_IND | K_DIR | K_BTB, 32'h999, 0, 0, 0, 32'h744, "R3 indirect miss");
    squash(10, 1, 1, 32'h555);
    exp_ret.push_back({32'h740, 1'b0, 1'b1});
    commit(10);

    predict(11, 32'h760, 0, 0, 0, 0, 0, 32'h764, "R2 cond nt 2");
    squash(12, 1, 1, 32'h333);
    chk("R11 mismatch flagged", n_mism, 1);
    exp_ret.push_back({32'h760, 1'b0, 1'b0});
    commit(11);
    squash(5, 1, 1, 32'h444);
    chk("R11 empty no flag", n_mism, 1);

    for (int i = 0; i < 16; i++)
      predict(16'(20 + i), 32'h1000 + 32'(4 * i), 0, 0, 0, 0, 0, 32'h1004 + 32'(4 * i), "R9 fill");
    @(posedge clk); #1;
    pred_seq = 36; pred_pc = 32'h2000; pred_valid = 1;
    #1 chk("R9 full not ready", pred_ready, 0);
    @(posedge clk); #1 pred_valid = 0;
    squash(19, 0, 0, 0);
    #1 chk("R9 ready after drain", pred_ready, 1);
    commit(100);

    predict(40, 32'h3000, 0, 0, 0, 0, 0, 32'h3004, "R10 setup");
    @(posedge clk); #1;
    sq_valid = 1; sq_seq = 0; sq_mispred = 0;
    commit_valid = 1; commit_seq = 100;
    pred_valid = 1; pred_seq = 50; pred_pc = 32'h3100;
    #1 chk("R10 ready low on requests", pred_ready, 0);
    @(posedge clk); #1;
    sq_valid = 0; commit_valid = 0; pred_valid = 0;
    chk("R10 busy", busy, 1);
    wait_idle();
    commit(100);

    @(posedge clk); #1;
    chk("R5 no pending retire", exp_ret.size(), 0);
    chk("R7 no pending btb", exp_btb.size(), 0);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_total, n_bad);
    $finish;
  end
endmodule